// File: doc/BRIEF.md
# Xon/Xoff software flow controller

This block runs in-band software flow control for one channel of a UART whose receive FIFO holds 64 characters. It has two halves that share only the token settings. The first half watches the receive FIFO fill level. When the level climbs to a programmable stop point, it asks the transmitter to send an Xoff token. When the level falls back to a lower resume point, it asks for an Xon token. The second half watches the stream of received characters for the programmed tokens. It then holds the local transmitter at its next character boundary, or lets it run again.

The transmitter signals each character boundary with `tx_boundary`. At such a boundary it takes `fc_char` whenever `fc_req` is high, and otherwise respects `tx_pause`. A character already on the line is never cut short. Tokens are one or two characters long. In an optional "resume on anything" mode, any character that arrives after an Xoff lets the transmitter run again. For each received character, `rx_push` tells the FIFO whether to store it. Baud generation, serialisation and the FIFOs themselves sit outside this block.

Top module: `swfc_ctrl`

## Requirements
- R1: After reset, `tx_pause` and `fc_req` are 0.
- R2: `cfg_thresh[3:0]` times 4 is the stop level. With `cfg_gen_en` high and no Xoff outstanding, a `rx_level` at or above the stop level raises `fc_req` one clock later with `fc_char` = `cfg_off_a`. A level one below the stop level raises nothing. `fc_req` never rises while `cfg_gen_en` is low.
- R3: `cfg_thresh[7:4]` times 4 is the resume level. After an Xoff has been requested, levels above the resume level request nothing more (hysteresis). A level at or below the resume level requests an Xon, with `fc_char` = `cfg_on_a`.
- R4: `fc_req` and `fc_char` hold steady until a cycle with `tx_boundary` high accepts them. With `cfg_pair_mode` = 1, a token goes out as its first character (`cfg_off_a` / `cfg_on_a`) and then its second (`cfg_off_b` / `cfg_on_b`), each on its own accepting boundary. `fc_req` drops in the cycle after the last accept.
- R5: A new level decision is made only when no token is in flight. So a stop level programmed at or below the resume level makes Xoff and Xon alternate, one whole token at a time, with no error.
- R6: With `cfg_obey_en` high, a received Xoff token (`cfg_off_a`, or `cfg_off_a` then `cfg_off_b` in pair mode) is not pushed. `tx_pause` then rises one clock after the next cycle in which `tx_boundary` is high, and never rises without such a cycle.
- R7: A received Xon token (`cfg_on_a`, or `cfg_on_a` then `cfg_on_b` in pair mode) is not pushed. `tx_pause` falls two clocks after the final token character. Other characters received while paused are pushed and leave the pause in place.
- R8: In pair mode, the first character of a token is held back and not pushed. If the next character does not complete the token, that next character is handled as fresh input, and the held character is discarded.
- R9: With `cfg_any_resume` = 1, the first character after a recognised Xoff that is neither an Xoff nor an Xon character is pushed, and it ends the pause.
- R10: With `cfg_any_resume` = 1 in pair mode, a `cfg_on_a` that arrives while paused ends the pause on its own and is not pushed. The `cfg_on_b` that follows is pushed as ordinary data.
- R11: With `cfg_obey_en` low, `rx_push` equals `rx_valid`, and `tx_pause` is 0 one clock later. With `cfg_gen_en` low, no new token is started, but a token already in flight is still handed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gen_en | input | 1 | Enable sending tokens from the FIFO level |
| cfg_obey_en | input | 1 | Enable acting on received tokens |
| cfg_pair_mode | input | 1 | 1: tokens are two characters; 0: one character |
| cfg_any_resume | input | 1 | Any character after an Xoff ends the pause |
| cfg_thresh | input | 8 | [3:0] stop level / 4, [7:4] resume level / 4 |
| cfg_on_a | input | 8 | Xon first (or only) character |
| cfg_on_b | input | 8 | Xon second character |
| cfg_off_a | input | 8 | Xoff first (or only) character |
| cfg_off_b | input | 8 | Xoff second character |
| rx_level | input | 7 | Receive FIFO fill level, 0 to 64 |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_char | input | 8 | Received character |
| tx_boundary | input | 1 | Transmitter is at a character boundary; accepts `fc_char` if requested |
| tx_pause | output | 1 | Transmitter must not start new data characters |
| fc_req | output | 1 | A flow-control character is waiting to be sent |
| fc_char | output | 8 | The flow-control character to send |
| rx_push | output | 1 | Store `rx_char` in the receive FIFO |

## Verification
The assertions assume two things about the inputs. The four token characters are distinct from one another. The token settings and the pair-mode bit stay fixed while a token is being requested, because `fc_char` is taken straight from them and the hold property would otherwise see a change. The bench writes every setting only while no request is pending, or to a value it already has, and it uses four different token characters throughout. It drives `tx_boundary` as single-cycle pulses, the way a transmitter marks the end of a character. It also sets the FIFO level directly to the boundary values 59, 60, 40, 33 and 32, instead of modelling a real FIFO.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  // Which token a held-back first character may be starting
  typedef enum logic [1:0] {
    PF_NONE = 2'd0,
    PF_OFF  = 2'd1,
    PF_ON   = 2'd2
  } pfx_e;

  // Kind of token being sent
  typedef enum logic {
    TK_ON  = 1'b0,
    TK_OFF = 1'b1
  } tok_e;
endpackage

// File: rtl/swfc_level_watch.sv
module swfc_level_watch import swfc_pkg::*; #(
  parameter int LVL_W    = 7,
  parameter int THR_W    = 4,
  parameter int SCALE_SH = 2,
  parameter int CHAR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                pair_mode,
  input  logic [2*THR_W-1:0]  thresh,
  input  logic [LVL_W-1:0]    level,
  input  logic [CHAR_W-1:0]   on_a,
  input  logic [CHAR_W-1:0]   on_b,
  input  logic [CHAR_W-1:0]   off_a,
  input  logic [CHAR_W-1:0]   off_b,
  input  logic                tx_boundary,
  output logic                req,
  output logic [CHAR_W-1:0]   req_char
);
  logic [LVL_W-1:0] stop_lvl, go_lvl;
  logic             halted_q, halted_n;
  logic             busy_q, busy_n;
  logic             idx_q, idx_n;
  tok_e             kind_q, kind_n;

  // Nibbles scaled to byte counts
  assign stop_lvl = LVL_W'(thresh[THR_W-1:0]) << SCALE_SH;
  assign go_lvl   = LVL_W'(thresh[2*THR_W-1:THR_W]) << SCALE_SH;

  always_comb begin
    halted_n = halted_q;
    busy_n   = busy_q;
    idx_n    = idx_q;
    kind_n   = kind_q;
    // Hand-off of the current character at a boundary
    if (busy_q && tx_boundary) begin
      if (pair_mode && !idx_q) begin
        idx_n = 1'b1;
      end else begin
        busy_n = 1'b0;
        idx_n  = 1'b0;
      end
    end
    // Level decisions only while nothing is in flight
    if (!busy_q) begin
      if (!en) begin
        halted_n = 1'b0;
      end else if (!halted_q && (level >= stop_lvl)) begin
        busy_n   = 1'b1;
        kind_n   = TK_OFF;
        halted_n = 1'b1;
      end else if (halted_q && (level <= go_lvl)) begin
        busy_n   = 1'b1;
        kind_n   = TK_ON;
        halted_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      busy_q   <= 1'b0;
      idx_q    <= 1'b0;
      kind_q   <= TK_ON;
    end else begin
      halted_q <= halted_n;
      busy_q   <= busy_n;
      idx_q    <= idx_n;
      kind_q   <= kind_n;
    end
  end

  assign req = busy_q;
  always_comb begin
    if (kind_q == TK_OFF) req_char = idx_q ? off_b : off_a;
    else                  req_char = idx_q ? on_b  : on_a;
  end
endmodule

// File: rtl/swfc_rx_match.sv
module swfc_rx_match import swfc_pkg::*; #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pair_mode,
  input  logic              any_resume,
  input  logic [CHAR_W-1:0] on_a,
  input  logic [CHAR_W-1:0] on_b,
  input  logic [CHAR_W-1:0] off_a,
  input  logic [CHAR_W-1:0] off_b,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              tx_boundary,
  output logic              push,
  output logic              pause
);
  pfx_e pfx_q, pfx_n;
  logic stopped_q, stopped_n;
  logic pause_q, pause_n;
  logic keep, fresh;

  always_comb begin
    keep      = 1'b1;
    fresh     = 1'b1;
    pfx_n     = pfx_q;
    stopped_n = stopped_q;
    if (!en) begin
      stopped_n = 1'b0;
      pfx_n     = PF_NONE;
    end else if (rx_valid) begin
      pfx_n = PF_NONE;
      // Completion of a two-character token
      if (pfx_q == PF_OFF && rx_char == off_b) begin
        keep      = 1'b0;
        stopped_n = 1'b1;
        fresh     = 1'b0;
      end else if (pfx_q == PF_ON && rx_char == on_b) begin
        keep      = 1'b0;
        stopped_n = 1'b0;
        fresh     = 1'b0;
      end
      if (fresh) begin
        if (rx_char == off_a) begin
          keep = 1'b0;
          if (pair_mode) pfx_n = PF_OFF;
          else           stopped_n = 1'b1;
        end else if (rx_char == on_a) begin
          keep = 1'b0;
          // Resume-on-anything swallows a lone first Xon character
          if (!pair_mode || (stopped_q && any_resume)) stopped_n = 1'b0;
          else                                         pfx_n = PF_ON;
        end else if (stopped_q && any_resume) begin
          stopped_n = 1'b0;
        end
      end
    end
  end

  // Pause is applied only at a character boundary; release follows at once
  assign pause_n = en && stopped_q && (pause_q || tx_boundary);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfx_q     <= PF_NONE;
      stopped_q <= 1'b0;
      pause_q   <= 1'b0;
    end else begin
      pfx_q     <= pfx_n;
      stopped_q <= stopped_n;
      pause_q   <= pause_n;
    end
  end

  assign push  = rx_valid && keep;
  assign pause = pause_q;
endmodule

// File: rtl/swfc_ctrl.sv
module swfc_ctrl #(
  parameter  int FIFO_DEPTH = 64,
  parameter  int THR_W      = 4,
  parameter  int CHAR_W     = 8,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_gen_en,
  input  logic               cfg_obey_en,
  input  logic               cfg_pair_mode,
  input  logic               cfg_any_resume,
  input  logic [2*THR_W-1:0] cfg_thresh,
  input  logic [CHAR_W-1:0]  cfg_on_a,
  input  logic [CHAR_W-1:0]  cfg_on_b,
  input  logic [CHAR_W-1:0]  cfg_off_a,
  input  logic [CHAR_W-1:0]  cfg_off_b,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic               rx_valid,
  input  logic [CHAR_W-1:0]  rx_char,
  input  logic               tx_boundary,
  output logic               tx_pause,
  output logic               fc_req,
  output logic [CHAR_W-1:0]  fc_char,
  output logic               rx_push
);
  localparam int SCALE_SH = $clog2(FIFO_DEPTH) - THR_W;

  swfc_level_watch #(
    .LVL_W(LVL_W), .THR_W(THR_W), .SCALE_SH(SCALE_SH), .CHAR_W(CHAR_W)
  ) i_level_watch (
    .clk(clk), .rst_n(rst_n), .en(cfg_gen_en), .pair_mode(cfg_pair_mode),
    .thresh(cfg_thresh), .level(rx_level),
    .on_a(cfg_on_a), .on_b(cfg_on_b), .off_a(cfg_off_a), .off_b(cfg_off_b),
    .tx_boundary(tx_boundary), .req(fc_req), .req_char(fc_char)
  );

  swfc_rx_match #(.CHAR_W(CHAR_W)) i_rx_match (
    .clk(clk), .rst_n(rst_n), .en(cfg_obey_en), .pair_mode(cfg_pair_mode),
    .any_resume(cfg_any_resume),
    .on_a(cfg_on_a), .on_b(cfg_on_b), .off_a(cfg_off_a), .off_b(cfg_off_b),
    .rx_valid(rx_valid), .rx_char(rx_char), .tx_boundary(tx_boundary),
    .push(rx_push), .pause(tx_pause)
  );
endmodule

// File: rtl/swfc_ctrl_chk.sv
module swfc_ctrl_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_gen_en,
  input logic              cfg_obey_en,
  input logic [CHAR_W-1:0] cfg_off_a,
  input logic              rx_valid,
  input logic [CHAR_W-1:0] rx_char,
  input logic              tx_boundary,
  input logic              tx_pause,
  input logic              fc_req,
  input logic [CHAR_W-1:0] fc_char,
  input logic              rx_push
);
  // R6: pause only ever starts right after a character boundary
  p_pause_on_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pause) |-> $past(tx_boundary));

  // R4: an unaccepted request holds its character
  p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_req && !tx_boundary) |=> (fc_req && $stable(fc_char)));

  // R6: an Xoff first character never reaches the FIFO
  p_off_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_obey_en && rx_valid && rx_char == cfg_off_a) |-> !rx_push);

  // R11: with reception control off every character passes
  p_pass_through_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_obey_en |-> (rx_push == rx_valid));

  // R11: with reception control off the pause clears
  p_no_pause_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_obey_en |=> !tx_pause);

  // R2: a request only starts while sending is enabled
  p_req_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fc_req) |-> $past(cfg_gen_en));
endmodule

bind swfc_ctrl swfc_ctrl_chk #(.CHAR_W(CHAR_W)) i_swfc_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .cfg_gen_en(cfg_gen_en), .cfg_obey_en(cfg_obey_en),
  .cfg_off_a(cfg_off_a), .rx_valid(rx_valid), .rx_char(rx_char),
  .tx_boundary(tx_boundary), .tx_pause(tx_pause), .fc_req(fc_req),
  .fc_char(fc_char), .rx_push(rx_push)
);

// File: tb/test_swfc_ctrl.sv
module test_swfc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_gen_en, cfg_obey_en, cfg_pair_mode, cfg_any_resume;
  logic [7:0] cfg_thresh, cfg_on_a, cfg_on_b, cfg_off_a, cfg_off_b;
  logic [6:0] rx_level;
  logic       rx_valid;
  logic [7:0] rx_char;
  logic       tx_boundary;
  logic       tx_pause, fc_req, rx_push;
  logic [7:0] fc_char;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam logic [7:0] OFF_A = 8'h0F, ON_A = 8'h0D, OFF_B = 8'h13, ON_B = 8'h11;

  always #2 clk = ~clk;

  swfc_ctrl i_swfc_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_gen_en(cfg_gen_en), .cfg_obey_en(cfg_obey_en),
    .cfg_pair_mode(cfg_pair_mode), .cfg_any_resume(cfg_any_resume),
    .cfg_thresh(cfg_thresh), .cfg_on_a(cfg_on_a), .cfg_on_b(cfg_on_b),
    .cfg_off_a(cfg_off_a), .cfg_off_b(cfg_off_b), .rx_level(rx_level),
    .rx_valid(rx_valid), .rx_char(rx_char), .tx_boundary(tx_boundary),
    .tx_pause(tx_pause), .fc_req(fc_req), .fc_char(fc_char), .rx_push(rx_push)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic accept();
    tx_boundary = 1'b1;
    @(negedge clk);
    tx_boundary = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] c, input logic exp_push, input string tag);
    rx_valid = 1'b1;
    rx_char  = c;
    #1;
    chk(tag, rx_push, exp_push);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 tx_pause after reset", tx_pause, 0);
    chk("R1 fc_req after reset", fc_req, 0);
  endtask

  task automatic t_halt_resume();
    cfg_gen_en = 1'b1;
    rx_level = 7'd59; cyc(1);
    chk("R2 below stop level", fc_req, 0);
    rx_level = 7'd60; cyc(1);
    chk("R2 stop level request", fc_req, 1);
    chk("R2 xoff char", fc_char, OFF_A);
    cyc(3);
    chk("R4 request held", fc_req, 1);
    accept();
    chk("R4 request drops after accept", fc_req, 0);
    rx_level = 7'd40; cyc(2);
    chk("R3 hysteresis above resume", fc_req, 0);
    rx_level = 7'd33; cyc(1);
    chk("R3 one above resume", fc_req, 0);
    rx_level = 7'd32; cyc(1);
    chk("R3 resume request", fc_req, 1);
    chk("R3 xon char", fc_char, ON_A);
    accept();
    chk("R3 xon accepted", fc_req, 0);
  endtask

  task automatic t_pair_send();
    cfg_pair_mode = 1'b1;
    rx_level = 7'd64; cyc(1);
    chk("R4 pair first xoff", fc_char, OFF_A);
    accept();
    chk("R4 pair still requesting", fc_req, 1);
    chk("R4 pair second xoff", fc_char, OFF_B);
    accept();
    chk("R4 pair done", fc_req, 0);
    rx_level = 7'd0; cyc(1);
    chk("R4 pair first xon", fc_char, ON_A);
    accept();
    chk("R4 pair second xon", fc_char, ON_B);
    accept();
    chk("R4 pair xon done", fc_req, 0);
    cfg_pair_mode = 1'b0;
  endtask

  task automatic t_misorder();
    cfg_thresh = 8'hF0;
    rx_level   = 7'd30;
    cyc(1);
    chk("R5 misordered first is xoff", fc_char, OFF_A);
    cyc(2);
    chk("R5 no change while in flight", fc_char, OFF_A);
    accept();
    cyc(1);
    chk("R5 then xon", fc_char, ON_A);
    accept();
    cyc(1);
    chk("R5 then xoff again", fc_char, OFF_A);
    cfg_gen_en = 1'b0;
    cyc(1);
    chk("R11 in-flight kept when disabled", fc_req, 1);
    accept();
    cyc(3);
    chk("R11 nothing new when disabled", fc_req, 0);
    cfg_thresh = 8'h8F;
  endtask

  task automatic t_rx_single();
    cfg_obey_en = 1'b1;
    rx_send(8'h41, 1'b1, "R7 plain data pushed");
    rx_send(OFF_A, 1'b0, "R6 xoff dropped");
    cyc(2);
    chk("R6 pause waits for boundary", tx_pause, 0);
    accept();
    chk("R6 pause at boundary", tx_pause, 1);
    rx_send(8'h42, 1'b1, "R7 data while paused pushed");
    chk("R7 still paused after data", tx_pause, 1);
    rx_send(ON_A, 1'b0, "R7 xon dropped");
    cyc(1);
    chk("R7 pause released", tx_pause, 0);
  endtask

  task automatic t_rx_pair();
    cfg_pair_mode = 1'b1;
    rx_send(OFF_A, 1'b0, "R8 first xoff held");
    rx_send(OFF_B, 1'b0, "R8 second xoff dropped");
    accept();
    chk("R8 pair xoff pauses", tx_pause, 1);
    rx_send(OFF_A, 1'b0, "R8 lone prefix held");
    rx_send(8'h41, 1'b1, "R8 non-completing char pushed");
    chk("R8 still paused", tx_pause, 1);
    rx_send(ON_A, 1'b0, "R8 first xon held");
    chk("R8 half xon keeps pause", tx_pause, 1);
    rx_send(ON_B, 1'b0, "R8 second xon dropped");
    cyc(1);
    chk("R8 pair xon resumes", tx_pause, 0);
    cfg_pair_mode = 1'b0;
  endtask

  task automatic t_any();
    cfg_any_resume = 1'b1;
    rx_send(OFF_A, 1'b0, "R9 xoff dropped");
    accept();
    chk("R9 paused", tx_pause, 1);
    rx_send(8'h55, 1'b1, "R9 any char pushed");
    cyc(1);
    chk("R9 any char resumes", tx_pause, 0);
    cfg_pair_mode = 1'b1;
    rx_send(OFF_A, 1'b0, "R10 xoff first dropped");
    rx_send(OFF_B, 1'b0, "R10 xoff second dropped");
    accept();
    chk("R10 paused", tx_pause, 1);
    rx_send(ON_A, 1'b0, "R10 first xon taken as any");
    rx_send(ON_B, 1'b1, "R10 second xon pushed as data");
    chk("R10 resumed", tx_pause, 0);
    cfg_pair_mode  = 1'b0;
    cfg_any_resume = 1'b0;
  endtask

  task automatic t_disable();
    rx_send(OFF_A, 1'b0, "R11 xoff before disable");
    accept();
    chk("R11 paused before disable", tx_pause, 1);
    cfg_obey_en = 1'b0;
    cyc(1);
    chk("R11 disable clears pause", tx_pause, 0);
    rx_send(OFF_A, 1'b1, "R11 xoff passes when disabled");
    accept();
    chk("R11 no pause when disabled", tx_pause, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_gen_en = 1'b0; cfg_obey_en = 1'b0; cfg_pair_mode = 1'b0; cfg_any_resume = 1'b0;
    cfg_thresh = 8'h8F;
    cfg_on_a = ON_A; cfg_on_b = ON_B; cfg_off_a = OFF_A; cfg_off_b = OFF_B;
    rx_level = '0; rx_valid = 1'b0; rx_char = '0; tx_boundary = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_halt_resume();
    t_pair_send();
    t_misorder();
    t_rx_single();
    t_rx_pair();
    t_any();
    t_disable();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule